// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Masked Output Writes

A general-purpose I/O port for 32 pins that sits on a simple 32-bit register bus. The bus has a write strobe, an address, write data and read data, and reads are combinational. Each pin has a direction bit, where 1 means the pin drives its pad. Software changes direction bits through two strobe registers. One register turns pins into outputs, the other turns pins into inputs, and neither needs a read-modify-write.

The output values are split into a lower half (pins 0..15) and an upper half (pins 16..31). Each half is updated with one word that carries both the new value and a per-bit write mask. This lets software change a single pin without disturbing the others.

The levels seen on the pads pass through a multi-flop synchronizer before they can be read. The block drives an output-enable bus and an output-data bus toward the pad ring. The output-data bus always shows the stored value, so a value written while a pin is still an input appears at the pad as soon as its enable rises.

Top module: `gpio_mwport`

## Requirements
- R1: A write to offset 0x00 sets the direction bit of every pin whose data bit is 1 (that pin becomes an output); pins whose data bit is 0 keep their direction.
- R2: A write to offset 0x04 clears the direction bit of every pin whose data bit is 1 (that pin becomes an input); other pins keep their direction.
- R3: A read of offset 0x00 or 0x04 returns the 32-bit direction state, 1 meaning output; pad_oe equals that state.
- R4: For a write to offset 0x08 (pins 0..15) or 0x0C (pins 16..31), bit k of the stored half takes data bit k only when data bit 16+k is 1; bits with a 0 mask, and the other half, keep their value.
- R5: A read of offset 0x10 returns pad_in through a two-flop synchronizer: a change on pad_in is readable after the second rising clock edge and not after the first.
- R6: The output latches keep and drive their value on pad_out whatever the direction state, so a value written while a pin is an input is on pad_out before and when its enable rises.
- R7: A read of offset 0x08 or 0x0C returns that stored 16-bit half in bits 15:0 with bits 31:16 zero.
- R8: After reset all direction bits are 0 (pad_oe = 0) and both output halves are 0.
- R9: A write to an unmapped offset (e.g. 0x14) changes no state, and a read of it returns 0.
- R10: With wr_en low, address and data on the bus change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W (8) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for addr, combinational |
| pad_in | input | DATA_W (32) | Pad levels, asynchronous |
| pad_oe | output | DATA_W (32) | Per-pin output enable |
| pad_out | output | DATA_W (32) | Per-pin output value |

## Verification
The bench builds the port with its defaults: 32 pins, an 8-bit address and a two-stage synchronizer. This makes both output halves and the full mask width reachable, along with the exact two-edge input latency. With 8 address bits an unmapped offset can be addressed, so both the ignored write and the zero read are exercised. Masked writes are tested with full, partial and empty masks, and direction set and clear strobes are mixed on both the lowest and the highest pin.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  localparam logic [7:0] OFS_DIR_SET = 8'h00;
  localparam logic [7:0] OFS_DIR_CLR = 8'h04;
  localparam logic [7:0] OFS_OUT_LO  = 8'h08;
  localparam logic [7:0] OFS_OUT_HI  = 8'h0C;
  localparam logic [7:0] OFS_PIN_IN  = 8'h10;

  typedef struct packed {
    logic dir_set;
    logic dir_clr;
    logic out_lo;
    logic out_hi;
    logic pin_in;
  } gpio_sel_t;
endpackage

// File: rtl/gpio_mw_dir.sv
module gpio_mw_dir #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] dir_q
);
  logic [W-1:0] dir_d;
  logic         dir_en;

  assign dir_en = set_stb | clr_stb;

  always_comb begin
    dir_d = dir_q;
    if (set_stb) dir_d = dir_d | bits;
    if (clr_stb) dir_d = dir_d & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end
endmodule

// File: rtl/gpio_mw_half.sv
module gpio_mw_half #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [HW-1:0] wval,
  input  logic [HW-1:0] wmask,
  output logic [HW-1:0] q
);
  logic [HW-1:0] d;

  always_comb begin
    d = (q & ~wmask) | (wval & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_stb) q <= d;
  end
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_mwport.sv
module gpio_mwport
  import gpio_mw_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_oe,
  output logic [DATA_W-1:0] pad_out
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NHALF  = 2;
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_DIR_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_DIR_CLR);
  localparam logic [ADDR_W-1:0] A_OLO = ADDR_W'(OFS_OUT_LO);
  localparam logic [ADDR_W-1:0] A_OHI = ADDR_W'(OFS_OUT_HI);
  localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(OFS_PIN_IN);

  gpio_sel_t         sel;
  logic [NHALF-1:0]  half_stb;
  logic [HALF_W-1:0] half_q [NHALF];
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] pin_sync;

  always_comb begin
    sel.dir_set = (addr == A_SET);
    sel.dir_clr = (addr == A_CLR);
    sel.out_lo  = (addr == A_OLO);
    sel.out_hi  = (addr == A_OHI);
    sel.pin_in  = (addr == A_PIN);
  end

  assign half_stb = {wr_en & sel.out_hi, wr_en & sel.out_lo};

  gpio_mw_dir #(.W(DATA_W)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (wr_en & sel.dir_set),
    .clr_stb (wr_en & sel.dir_clr),
    .bits    (wdata),
    .dir_q   (dir_q)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    gpio_mw_half #(.HW(HALF_W)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (half_stb[h]),
      .wval   (wdata[HALF_W-1:0]),
      .wmask  (wdata[DATA_W-1:HALF_W]),
      .q      (half_q[h])
    );
    assign pad_out[h*HALF_W +: HALF_W] = half_q[h];
  end

  gpio_mw_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pad_in),
    .dout  (pin_sync)
  );

  assign pad_oe = dir_q;

  always_comb begin
    rdata = '0;
    if (sel.dir_set || sel.dir_clr) rdata = dir_q;
    else if (sel.out_lo)            rdata = {{HALF_W{1'b0}}, half_q[0]};
    else if (sel.out_hi)            rdata = {{HALF_W{1'b0}}, half_q[1]};
    else if (sel.pin_in)            rdata = pin_sync;
  end
endmodule

// File: rtl/gpio_mwport_chk.sv
module gpio_mwport_chk
  import gpio_mw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] pad_oe,
  input logic [DATA_W-1:0] pad_out
);
  localparam int HALF_W = DATA_W / 2;
  logic wr_set, wr_clr, wr_lo, wr_hi;
  assign wr_set = wr_en && (addr == ADDR_W'(OFS_DIR_SET));
  assign wr_clr = wr_en && (addr == ADDR_W'(OFS_DIR_CLR));
  assign wr_lo  = wr_en && (addr == ADDR_W'(OFS_OUT_LO));
  assign wr_hi  = wr_en && (addr == ADDR_W'(OFS_OUT_HI));

  assert_dir_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pad_oe & $past(wdata)) == $past(wdata)) &&
               ((pad_oe & ~$past(wdata)) == ($past(pad_oe) & ~$past(wdata))));

  assert_dir_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pad_oe & $past(wdata)) == '0) &&
               ((pad_oe & ~$past(wdata)) == ($past(pad_oe) & ~$past(wdata))));

  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(pad_oe));

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi) |=> $stable(pad_out));

  assert_lo_spares_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> $stable(pad_out[DATA_W-1:HALF_W]));

  assert_hi_spares_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> $stable(pad_out[HALF_W-1:0]));
endmodule

bind gpio_mwport gpio_mwport_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .pad_oe  (pad_oe),
  .pad_out (pad_out)
);

// File: tb/gpio_mwport_bench.sv
module gpio_mwport_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_oe;
  logic [31:0] pad_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  gpio_mwport u_gpio_mwport (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  // monitor: pops and compares at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? pad_oe : pad_out;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%08h expected=%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    addr = a;
    exp_q.push_back('{0, e, t});
  endtask

  task automatic exp_pad(input int k, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back('{k, e, t});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 8'h00; wdata = '0; pad_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8 reset state
    exp_rd(8'h04, 32'h0, "R8 dir after reset");
    exp_rd(8'h08, 32'h0, "R8 out_lo after reset");
    exp_rd(8'h0C, 32'h0, "R8 out_hi after reset");
    exp_pad(1, 32'h0, "R8 pad_oe after reset");
    exp_pad(2, 32'h0, "R8 pad_out after reset");

    // R6: value written while pins are inputs
    wr(8'h08, 32'hFFFF_A5A5);
    exp_pad(2, 32'h0000_A5A5, "R6 pad_out driven while input");
    exp_pad(1, 32'h0, "R6 pad_oe still low");
    // R4 partial mask, then empty mask
    wr(8'h08, 32'h00F0_0F0F);
    exp_rd(8'h08, 32'h0000_A505, "R4 partial mask");
    wr(8'h08, 32'h0000_FFFF);
    exp_rd(8'h08, 32'h0000_A505, "R4 empty mask");
    wr(8'h0C, 32'hFFFF_1234);
    exp_pad(2, 32'h1234_A505, "R4 upper half leaves lower");
    exp_rd(8'h0C, 32'h0000_1234, "R7 out_hi readback");
    exp_rd(8'h08, 32'h0000_A505, "R7 out_lo readback");

    // R1 / R6 enable rises with the stored value already present
    wr(8'h00, 32'h0000_00FF);
    exp_pad(1, 32'h0000_00FF, "R1 set low byte");
    exp_pad(2, 32'h1234_A505, "R6 value at oe rise");
    wr(8'h00, 32'h8000_0000);
    exp_pad(1, 32'h8000_00FF, "R1 set pin 31 keeps others");
    // R2 / R3
    wr(8'h04, 32'h0000_000F);
    exp_pad(1, 32'h8000_00F0, "R2 clear low nibble");
    exp_rd(8'h04, 32'h8000_00F0, "R3 dir read at 0x04");
    exp_rd(8'h00, 32'h8000_00F0, "R3 dir read at 0x00");

    // R9 unmapped offset
    wr(8'h14, 32'hFFFF_FFFF);
    exp_pad(1, 32'h8000_00F0, "R9 oe unchanged");
    exp_pad(2, 32'h1234_A505, "R9 out unchanged");
    exp_rd(8'h14, 32'h0, "R9 read zero");

    // R10 bus activity without strobe
    @(posedge clk); #1;
    wr_en = 1'b0; addr = 8'h00; wdata = 32'hFFFF_FFFF;
    exp_pad(1, 32'h8000_00F0, "R10 set without strobe");
    addr = 8'h08;
    exp_pad(2, 32'h1234_A505, "R10 out without strobe");

    // R5 two-edge synchronizer
    @(posedge clk); #1;
    addr = 8'h10;
    pad_in = 32'hDEAD_BEEF;
    exp_rd(8'h10, 32'h0, "R5 not after first edge");
    exp_rd(8'h10, 32'hDEAD_BEEF, "R5 after second edge");

    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule